// File: doc/BRIEF.md
# 10G Transmit Inter-Packet Gap Controller

This block sits on the transmit path of a 10G MAC, between the source of outgoing frames and the line-side encoder. It decides in which cycles a new frame may begin. After the last beat of each frame it holds off the next frame start for an idle gap. It also holds off frame starts while a pause interval, requested by a received flow-control frame, is still running. Beats of a frame that has already started are never held back.

The gap has two modes, chosen by a configuration bit. A single 10-bit gap field is read differently in each mode. In LAN mode the field is a number of idle octets, taken in steps of four; the legal range is 8 to 100 and the reset value is 12. In WAN mode the field is a stretch factor `v`, legal from 4 to 15. The gap then scales with the length of the frame just sent: the idle octet count is the frame length divided by the ratio `(v+1)*8`, rounded up to a multiple of four. A larger `v` therefore gives a shorter gap. The datapath moves `DATA_BYTES` octets per cycle, so every octet count becomes a whole number of idle cycles, rounded up. Averaging of idle deficits across frames is not done.

A pause request carries a count of quanta, where one quantum is 512 bit-times. That is 8 cycles at the default 8-byte beat. A new request replaces the running interval. Requests are dropped completely while the pause-ignore bit is set. A transmit-enable bit gates every frame start.

Top module: `xgmac_tx_gap_ctrl`

## Requirements
- R1: After reset there is no pending gap, no running pause and no open frame, so `src_ready` equals `cfg_tx_en`.
- R2: While no frame is open, `cfg_tx_en` low forces `src_ready` low. Clearing `cfg_tx_en` in the middle of a frame does not stall the remaining beats of that frame.
- R3: In LAN mode (`cfg_wan_mode`=0), the gap field is taken with its two low bits cleared, giving an octet count. After the beat where `src_valid`, `src_ready` and `src_last` are all high, `src_ready` stays low for exactly ceil(octets / `DATA_BYTES`) cycles. With 8-byte beats, values 8, 12, 13 and 100 give 1, 2, 2 and 13 cycles.
- R4: In WAN mode (`cfg_wan_mode`=1), with `src_len` the byte length presented on the last beat, `src_ready` stays low for exactly ceil(`src_len` / ((v+1)·8·`DATA_BYTES`)) cycles after the last beat. A length of 0 gives no gap.
- R5: In WAN mode a larger stretch factor gives a gap no longer than a smaller one for the same length. For example, length 1000 gives 4 cycles at v=4 and 1 cycle at v=15.
- R6: A `pause_load` pulse with pause-ignore clear holds `src_ready` low for exactly `pause_quanta`·(512 / (8·`DATA_BYTES`)) cycles, starting the cycle after the pulse.
- R7: A new `pause_load` replaces the remaining pause interval. A load of 0 quanta ends the pause, so `src_ready` is high again in the next cycle.
- R8: While `cfg_pause_ignore` is set, `pause_load` has no effect on `src_ready`.
- R9: A pause that arrives during a frame does not stall that frame. The pause interval keeps counting down, and only the next frame start waits for it.
- R10: When a gap and a pause overlap, the next frame start waits until both have expired.
- R11: The gap counts down in every cycle, whether or not `src_valid` is high, and `src_ready` does not depend on `src_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_tx_en | input | 1 | Allows new frame starts |
| cfg_wan_mode | input | 1 | 0 selects the LAN octet gap, 1 selects the WAN stretch gap |
| cfg_pause_ignore | input | 1 | Drops incoming pause requests |
| cfg_gap_val | input | GAP_W | Octet count (LAN mode) or stretch factor (WAN mode) |
| src_valid | input | 1 | Source presents a beat |
| src_ready | output | 1 | Beat may be accepted this cycle |
| src_last | input | 1 | Beat is the last of its frame |
| src_len | input | LEN_W | Frame byte length, sampled on the last beat |
| pause_load | input | 1 | One-cycle pulse: a pause request was received |
| pause_quanta | input | QUANTA_W | Requested pause length in quanta |

## Verification
The bench builds the block with its default parameters: 8-byte beats, a 10-bit gap field, a 14-bit length and 16-bit quanta. At 8 bytes per beat one quantum is 8 cycles, so pause intervals of a few quanta can be measured cycle by cycle. The WAN divisor for v=4..15 is 320 to 1024 bytes per idle cycle, so lengths placed just below, at and just above a multiple of that divisor exercise the round-up of R4. LAN values 8, 13 and 100 cover the smallest gap, the low-bit masking and the largest gap.

// File: rtl/txgap_pkg.sv
// Package txgap_pkg
// Shared constants and the gap mode type of the transmit gap controller.
// Assumes: a pause quantum is a fixed number of bit-times.
package txgap_pkg;
    localparam int PAUSE_QUANTUM_BITS = 512;
    localparam int LAN_ALIGN_BITS     = 2;

    typedef enum logic {
        GAP_LAN = 1'b0,
        GAP_WAN = 1'b1
    } gap_mode_e;
endpackage

// File: rtl/txgap_credit_unit.sv
// Module txgap_credit_unit
// Holds the idle credit still owed after a frame. On load it takes a credit
// and a per-cycle step. It then lowers the credit by one step per cycle,
// stopping at zero. The gap is over when the credit is zero.
// Assumes: step_i is nonzero whenever load_i is high.
module txgap_credit_unit #(
    parameter int CRED_W = 14,
    parameter int STEP_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [CRED_W-1:0] load_val_i,
    input  logic [STEP_W-1:0] step_i,
    output logic              clear_o
);
    localparam int CMP_W = (CRED_W > STEP_W) ? CRED_W : STEP_W;

    logic [CRED_W-1:0] credit_q;
    logic [CRED_W-1:0] credit_next;
    logic [STEP_W-1:0] step_q;
    logic [CMP_W-1:0]  credit_ext;
    logic [CMP_W-1:0]  step_ext;
    logic [CMP_W-1:0]  diff;

    // Next credit: lower by one step, never below zero
    always_comb begin
        credit_ext = CMP_W'(credit_q);
        step_ext   = CMP_W'(step_q);
        diff       = credit_ext - step_ext;
        if (credit_ext <= step_ext) credit_next = '0;
        else                        credit_next = diff[CRED_W-1:0];
    end

    // Credit and step registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_q <= '0;
            step_q   <= '0;
        end else if (load_i) begin
            credit_q <= load_val_i;
            step_q   <= step_i;
        end else begin
            credit_q <= credit_next;
        end
    end

    assign clear_o = (credit_q == '0);

    // R4: an unloaded, nonzero credit shrinks every cycle
    assert_credit_drains_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && credit_q != '0) |=> (credit_q < $past(credit_q)));

    // R4: loading a zero credit gives no gap
    assert_zero_len_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && load_val_i == '0) |=> clear_o);
endmodule

// File: rtl/txgap_pause_timer.sv
// Module txgap_pause_timer
// Counts down the pause interval in cycles. An accepted request reloads the
// counter with quanta times the cycles per quantum. Requests are dropped
// while ignore_i is high.
// Assumes: CYC_PER_QUANTUM is at least 1.
module txgap_pause_timer #(
    parameter int QUANTA_W        = 16,
    parameter int CYC_PER_QUANTUM = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic                ignore_i,
    input  logic [QUANTA_W-1:0] quanta_i,
    output logic                idle_o
);
    localparam int CNT_W = QUANTA_W + $clog2(CYC_PER_QUANTUM + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             take;

    assign take = load_i && !ignore_i;

    // Pause counter: reload on an accepted request, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= CNT_W'(quanta_i) * CNT_W'(CYC_PER_QUANTUM);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign idle_o = (cnt_q == '0);

    // R6: a running pause counts down by exactly one per cycle
    assert_pause_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: a zero-quanta request ends the pause at once
    assert_pause_zero_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && quanta_i == '0) |=> idle_o);

    // R8: an ignored request does not start a pause
    assert_pause_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && ignore_i && cnt_q == '0) |=> idle_o);
endmodule

// File: rtl/xgmac_tx_gap_ctrl.sv
// Module xgmac_tx_gap_ctrl
// Grants frame starts on the transmit side of a 10G MAC. It enforces the idle
// gap after each frame, in LAN octet mode or WAN stretch mode, and it stalls
// starts during a received pause interval. Beats inside a frame always pass.
// Assumes: DATA_BYTES is a power of two no larger than 64, LEN_W >= GAP_W,
// and src_len is valid on the last beat of each frame.
module xgmac_tx_gap_ctrl #(
    parameter int DATA_BYTES = 8,
    parameter int GAP_W      = 10,
    parameter int LEN_W      = 14,
    parameter int QUANTA_W   = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_tx_en,
    input  logic                cfg_wan_mode,
    input  logic                cfg_pause_ignore,
    input  logic [GAP_W-1:0]    cfg_gap_val,
    input  logic                src_valid,
    output logic                src_ready,
    input  logic                src_last,
    input  logic [LEN_W-1:0]    src_len,
    input  logic                pause_load,
    input  logic [QUANTA_W-1:0] pause_quanta
);
    import txgap_pkg::*;

    localparam int BEAT_BITS       = 8 * DATA_BYTES;
    localparam int CYC_PER_QUANTUM = PAUSE_QUANTUM_BITS / BEAT_BITS;
    localparam int CRED_W          = (LEN_W > GAP_W) ? LEN_W : GAP_W;
    localparam int STEP_W          = GAP_W + 1 + $clog2(BEAT_BITS);

    gap_mode_e         mode;
    logic              beat;
    logic              last_beat;
    logic              in_frame_q;
    logic              gap_clear;
    logic              pause_clear;
    logic [GAP_W-1:0]  lan_octets;
    logic [CRED_W-1:0] credit_load;
    logic [STEP_W-1:0] credit_step;

    assign mode      = gap_mode_e'(cfg_wan_mode);
    assign beat      = src_valid && src_ready;
    assign last_beat = beat && src_last;

    // Frame tracking: open on a non-final beat, close on the last beat
    always_ff @(posedge clk) begin
        if (!rst_n)    in_frame_q <= 1'b0;
        else if (beat) in_frame_q <= !src_last;
    end

    // Credit and step chosen by mode: LAN octets at beat width, or WAN length at stretched width
    always_comb begin
        lan_octets = {cfg_gap_val[GAP_W-1:LAN_ALIGN_BITS], {LAN_ALIGN_BITS{1'b0}}};
        if (mode == GAP_WAN) begin
            credit_load = CRED_W'(src_len);
            credit_step = (STEP_W'(cfg_gap_val) + 1'b1) * STEP_W'(BEAT_BITS);
        end else begin
            credit_load = CRED_W'(lan_octets);
            credit_step = STEP_W'(DATA_BYTES);
        end
    end

    txgap_credit_unit #(
        .CRED_W (CRED_W),
        .STEP_W (STEP_W)
    ) u_credit (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (last_beat),
        .load_val_i (credit_load),
        .step_i     (credit_step),
        .clear_o    (gap_clear)
    );

    txgap_pause_timer #(
        .QUANTA_W        (QUANTA_W),
        .CYC_PER_QUANTUM (CYC_PER_QUANTUM)
    ) u_pause (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (pause_load),
        .ignore_i (cfg_pause_ignore),
        .quanta_i (pause_quanta),
        .idle_o   (pause_clear)
    );

    assign src_ready = in_frame_q || (cfg_tx_en && gap_clear && pause_clear);

    // R3: a nonzero LAN gap blocks the cycle after the last beat
    assert_gap_follows_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (last_beat && mode == GAP_LAN && lan_octets != '0) |=> !src_ready);

    // R2: no frame start while transmit is disabled
    assert_txen_gates_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame_q && !cfg_tx_en) |-> !src_ready);

    // R9: once a frame is open, its next beat is never stalled
    assert_frame_not_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && !src_last) |=> src_ready);
endmodule

// File: tb/xgmac_tx_gap_ctrl_test.sv
module xgmac_tx_gap_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_tx_en = 1'b1;
    logic        cfg_wan_mode = 1'b0;
    logic        cfg_pause_ignore = 1'b0;
    logic [9:0]  cfg_gap_val = 10'd12;
    logic        src_valid = 1'b0;
    logic        src_ready;
    logic        src_last = 1'b0;
    logic [13:0] src_len = '0;
    logic        pause_load = 1'b0;
    logic [15:0] pause_quanta = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    xgmac_tx_gap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_tx_en(cfg_tx_en), .cfg_wan_mode(cfg_wan_mode),
        .cfg_pause_ignore(cfg_pause_ignore), .cfg_gap_val(cfg_gap_val),
        .src_valid(src_valid), .src_ready(src_ready), .src_last(src_last),
        .src_len(src_len), .pause_load(pause_load), .pause_quanta(pause_quanta)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count consecutive low-ready cycles starting from the current cycle
    task automatic measure_low(output int n);
        n = 0;
        #1;
        while (!src_ready && n < 2000) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    // Send one frame; optional pause pulse and tx disable at given beats
    task automatic send_frame(input int beats, input int len, input int pause_at,
                              input int pq, input int txoff_at, output int stalls);
        stalls = 0;
        for (int i = 0; i < beats; i++) begin
            @(negedge clk);
            src_valid = 1'b1;
            src_last  = (i == beats - 1);
            src_len   = 14'(len);
            if (i == txoff_at) cfg_tx_en = 1'b0;
            if (i == pause_at) begin
                pause_load   = 1'b1;
                pause_quanta = 16'(pq);
            end else begin
                pause_load = 1'b0;
            end
            #1;
            while (!src_ready) begin
                stalls++;
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        src_valid  = 1'b0;
        src_last   = 1'b0;
        pause_load = 1'b0;
    endtask

    task automatic pulse_pause(input int q);
        @(negedge clk);
        pause_load   = 1'b1;
        pause_quanta = 16'(q);
        @(negedge clk);
        pause_load = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(src_ready == 1'b1, "R1 ready after reset", src_ready, 1);
        cfg_tx_en = 1'b0;
        #1;
        check(src_ready == 1'b0, "R1 ready follows tx_en", src_ready, 0);
        cfg_tx_en = 1'b1;
    endtask

    task automatic t_lan(input int val, input int exp);
        int st, n;
        cfg_wan_mode = 1'b0;
        cfg_gap_val  = 10'(val);
        send_frame(2, 64, -1, 0, -1, st);
        measure_low(n);
        check(n == exp, $sformatf("R3 LAN gap val %0d (R11 valid low)", val), n, exp);
    endtask

    task automatic t_wan(input int val, input int len, input int exp, input string req);
        int st, n;
        cfg_wan_mode = 1'b1;
        cfg_gap_val  = 10'(val);
        send_frame(2, len, -1, 0, -1, st);
        measure_low(n);
        check(n == exp, $sformatf("%s WAN v %0d len %0d", req, val, len), n, exp);
        cfg_wan_mode = 1'b0;
        cfg_gap_val  = 10'd12;
    endtask

    task automatic t_pause;
        int n;
        pulse_pause(3);
        measure_low(n);
        check(n == 24, "R6 pause 3 quanta", n, 24);
        pulse_pause(1);
        measure_low(n);
        check(n == 8, "R6 pause 1 quantum", n, 8);
    endtask

    task automatic t_reload;
        int n;
        pulse_pause(4);
        repeat (4) @(negedge clk);
        pulse_pause(1);
        measure_low(n);
        check(n == 8, "R7 reload replaces interval", n, 8);
        pulse_pause(3);
        repeat (2) @(negedge clk);
        pulse_pause(0);
        measure_low(n);
        check(n == 0, "R7 zero quanta ends pause", n, 0);
    endtask

    task automatic t_ignore;
        int n;
        cfg_pause_ignore = 1'b1;
        pulse_pause(5);
        measure_low(n);
        check(n == 0, "R8 ignored pause", n, 0);
        cfg_pause_ignore = 1'b0;
    endtask

    task automatic t_not_cut;
        int st, n;
        cfg_gap_val = 10'd12;
        send_frame(4, 256, 1, 2, -1, st);
        check(st == 0, "R9 frame beats not stalled", st, 0);
        measure_low(n);
        check(n == 14, "R9 pause holds next start", n, 14);
    endtask

    task automatic t_overlap;
        int st, n;
        cfg_gap_val = 10'd12;
        send_frame(2, 64, 1, 3, -1, st);
        measure_low(n);
        check(n == 24, "R10 pause longer than gap", n, 24);
        cfg_gap_val = 10'd100;
        send_frame(2, 64, 1, 1, -1, st);
        measure_low(n);
        check(n == 13, "R10 gap longer than pause", n, 13);
        cfg_gap_val = 10'd12;
    endtask

    task automatic t_txen;
        int st;
        send_frame(4, 256, -1, 0, 1, st);
        check(st == 0, "R2 frame finishes with tx_en low", st, 0);
        repeat (4) @(negedge clk);
        #1;
        check(src_ready == 1'b0, "R2 no start with tx_en low", src_ready, 0);
        cfg_tx_en = 1'b1;
        #1;
        check(src_ready == 1'b1, "R2 start after tx_en set", src_ready, 1);
    endtask

    initial begin
        t_reset();
        t_lan(12, 2);
        t_lan(8, 1);
        t_lan(13, 2);
        t_lan(100, 13);
        t_wan(12, 64, 1, "R4");
        t_wan(12, 1664, 2, "R4");
        t_wan(12, 1665, 3, "R4");
        t_wan(12, 0, 0, "R4");
        t_wan(4, 1000, 4, "R5");
        t_wan(15, 1000, 1, "R5");
        t_pause();
        t_reload();
        t_ignore();
        t_not_cut();
        t_overlap();
        t_txen();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule